// File: doc/BRIEF.md
# Register-Window Availability Tracker

This block keeps the bookkeeping for a processor with a circular file of register windows. It holds four availability counters: windows free to save into, windows that can be restored, windows owned by another context, and windows known to be clean. It also holds the current window pointer and a six-bit trap-selection field. Each cycle the pipeline may issue one window operation: save, restore, flush-all-windows, saved (a spill handler finished), restored (a fill handler finished), an architectural pointer write, or a bulk load of the counters and selection field.

For a save, restore or flush that cannot go ahead, the block does not move the pointer or touch the counters. It raises a one-cycle trap indication with a computed vector instead. Spill and fill vectors are formed from a base value and one of two three-bit groups of the selection field. When the other-context counter is nonzero, the upper group is used and an extra flag is added; otherwise the lower group is used. The pointer is exposed in reversed form, window count minus one minus the internal pointer. This is the value software reads and writes.

Top module: `win_state_unit`

## Requirements
- R1: After synchronous reset the outputs are: free-to-save = NWIN-2, restorable = 0, other = 0, clean = NWIN-1, cwp = NWIN-1 (internal pointer 0), trap_valid = 0, trap_type = 0.
- R2: A save (op 1) with free-to-save = 0 raises a spill trap; when other = 0 its type is 0x80 | (wstate[2:0] << 2).
- R3: When other != 0, spill and fill trap types are base | 0x20 | (wstate[5:3] << 2), with the spill base 0x80 and the fill base 0xC0.
- R4: A save with free-to-save != 0 and clean equal to restorable raises a clean-window trap of type 0x24.
- R5: A save that does not trap decrements free-to-save, increments restorable and increments the architectural cwp modulo NWIN.
- R6: A restore (op 2) with restorable = 0 raises a fill trap of type 0xC0 | (wstate[2:0] << 2) when other = 0.
- R7: A restore that does not trap increments free-to-save, decrements restorable and decrements the architectural cwp modulo NWIN.
- R8: A flush (op 3) raises a spill trap, encoded as in R2/R3, exactly when free-to-save != NWIN-2, and never changes any counter or the pointer.
- R9: A saved (op 4) increments free-to-save, then decrements restorable if other = 0, or decrements other otherwise.
- R10: A restored (op 5) increments restorable, increments clean only while clean < NWIN-1, then decrements free-to-save if other = 0, or decrements other otherwise.
- R11: A pointer write (op 6) of set_val makes cwp read back as set_val mod NWIN; a load (op 7) copies the ld_* inputs into the counters and the selection field.
- R12: A trapping operation leaves all counters and cwp unchanged.
- R13: Every result appears at the first rising edge after the op is presented; trap_valid is high for that one cycle only, and is 0 after an idle op (op 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation: 0 idle, 1 save, 2 restore, 3 flush, 4 saved, 5 restored, 6 pointer write, 7 load |
| set_val | input | WV | Architectural pointer value for op 6, reduced modulo NWIN |
| ld_cansave | input | CW | Free-to-save value for op 7 |
| ld_canrestore | input | CW | Restorable value for op 7 |
| ld_otherwin | input | CW | Other-context value for op 7 |
| ld_cleanwin | input | CW | Clean value for op 7 |
| ld_wstate | input | 6 | Trap-selection field for op 7 |
| cansave | output | CW | Free-to-save counter |
| canrestore | output | CW | Restorable counter |
| otherwin | output | CW | Other-context counter |
| cleanwin | output | CW | Clean counter |
| cwp | output | CW | Architectural window pointer |
| trap_valid | output | 1 | Trap raised by the previous op |
| trap_type | output | 8 | Trap vector, 0 when no trap |

## Verification
Each op is registered once, so the counters, cwp and trap outputs all change at the first rising edge after the op cycle. The bench drives inputs on falling edges and reads results at the next falling edge, one full cycle later. The sweep loads a counter state, writes the pointer, issues one op, and then checks every output in the cycle after that op. A separate sequence confirms that the trap indication is gone one cycle later.

// File: rtl/win_pkg.sv
package win_pkg;

    typedef enum logic [2:0] {
        WOP_IDLE     = 3'd0,
        WOP_SAVE     = 3'd1,
        WOP_RESTORE  = 3'd2,
        WOP_FLUSH    = 3'd3,
        WOP_SAVED    = 3'd4,
        WOP_RESTORED = 3'd5,
        WOP_SETCWP   = 3'd6,
        WOP_LOAD     = 3'd7
    } win_op_e;

    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_SPILL = 2'd1,
        TK_FILL  = 2'd2,
        TK_CLEAN = 2'd3
    } trap_kind_e;

    typedef enum logic [1:0] {
        PS_HOLD = 2'd0,
        PS_INC  = 2'd1,
        PS_DEC  = 2'd2,
        PS_SET  = 2'd3
    } ptr_step_e;

    localparam int          TT_W         = 8;
    localparam int          WS_W         = 6;
    localparam logic [7:0]  TT_SPILL     = 8'h80;
    localparam logic [7:0]  TT_FILL      = 8'hC0;
    localparam logic [7:0]  TT_OTHERFLAG = 8'h20;
    localparam logic [7:0]  TT_CLEANWIN  = 8'h24;

    // Vector = base, plus selection group in bits 4:2, plus flag for other context
    function automatic logic [7:0] vec_code(logic [7:0] base, logic other,
                                            logic [WS_W-1:0] ws);
        logic [2:0] grp;
        grp = other ? ws[5:3] : ws[2:0];
        return base | (other ? TT_OTHERFLAG : 8'h00) | {3'b000, grp, 2'b00};
    endfunction

endpackage

// File: rtl/win_trap_enc.sv
module win_trap_enc
    import win_pkg::*;
(
    input  trap_kind_e        kind,
    input  logic              other_nz,
    input  logic [WS_W-1:0]   ws,
    output logic [TT_W-1:0]   code
);
    always_comb begin
        unique case (kind)
            TK_SPILL: code = vec_code(TT_SPILL, other_nz, ws);
            TK_FILL:  code = vec_code(TT_FILL,  other_nz, ws);
            TK_CLEAN: code = TT_CLEANWIN;
            default:  code = '0;
        endcase
    end
endmodule

// File: rtl/win_op_decide.sv
module win_op_decide
    import win_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input  win_op_e          op,
    input  logic [CW-1:0]    cs,
    input  logic [CW-1:0]    cr,
    input  logic [CW-1:0]    ow,
    input  logic [CW-1:0]    cl,
    input  logic [CW-1:0]    ld_cs,
    input  logic [CW-1:0]    ld_cr,
    input  logic [CW-1:0]    ld_ow,
    input  logic [CW-1:0]    ld_cl,
    output logic [CW-1:0]    cs_n,
    output logic [CW-1:0]    cr_n,
    output logic [CW-1:0]    ow_n,
    output logic [CW-1:0]    cl_n,
    output trap_kind_e       kind,
    output ptr_step_e        step
);
    localparam logic [CW-1:0] ONE      = CW'(1);
    localparam logic [CW-1:0] TOPV     = CW'(NWIN - 1);
    localparam logic [CW-1:0] FLUSH_OK = CW'(NWIN - 2);

    always_comb begin
        cs_n = cs;
        cr_n = cr;
        ow_n = ow;
        cl_n = cl;
        kind = TK_NONE;
        step = PS_HOLD;
        unique case (op)
            WOP_SAVE: begin
                if (cs == '0)
                    kind = TK_SPILL;
                else if (cl == cr)
                    kind = TK_CLEAN;
                else begin
                    cs_n = cs - ONE;
                    cr_n = cr + ONE;
                    step = PS_DEC;
                end
            end
            WOP_RESTORE: begin
                if (cr == '0)
                    kind = TK_FILL;
                else begin
                    cs_n = cs + ONE;
                    cr_n = cr - ONE;
                    step = PS_INC;
                end
            end
            WOP_FLUSH: begin
                if (cs != FLUSH_OK)
                    kind = TK_SPILL;
            end
            WOP_SAVED: begin
                cs_n = cs + ONE;
                if (ow == '0) cr_n = cr - ONE;
                else          ow_n = ow - ONE;
            end
            WOP_RESTORED: begin
                cr_n = cr + ONE;
                if (cl < TOPV) cl_n = cl + ONE;
                if (ow == '0) cs_n = cs - ONE;
                else          ow_n = ow - ONE;
            end
            WOP_SETCWP: step = PS_SET;
            WOP_LOAD: begin
                cs_n = ld_cs;
                cr_n = ld_cr;
                ow_n = ld_ow;
                cl_n = ld_cl;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/win_cwp_reg.sv
module win_cwp_reg
    import win_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN),
    parameter int WV   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  ptr_step_e       step,
    input  logic [WV-1:0]   wr_val,
    output logic [CW-1:0]   arch
);
    localparam logic [CW-1:0] TOPV = CW'(NWIN - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] ptr;
    logic [CW-1:0] wr_mod;

    assign wr_mod = CW'(wr_val % WV'(NWIN));
    assign arch   = TOPV - ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            unique case (step)
                PS_INC:  ptr <= (ptr == TOPV) ? '0 : ptr + ONE;
                PS_DEC:  ptr <= (ptr == '0) ? TOPV : ptr - ONE;
                PS_SET:  ptr <= TOPV - wr_mod;
                default: ptr <= ptr;
            endcase
        end
    end

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ptr <= TOPV); // R11

    AST_PTR_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (step == PS_INC && ptr == TOPV) |=> ptr == '0); // R7

    AST_PTR_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (step == PS_DEC && ptr == '0) |=> ptr == TOPV); // R5
endmodule

// File: rtl/win_state_unit.sv
module win_state_unit
    import win_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN),
    parameter int WV   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op,
    input  logic [WV-1:0]     set_val,
    input  logic [CW-1:0]     ld_cansave,
    input  logic [CW-1:0]     ld_canrestore,
    input  logic [CW-1:0]     ld_otherwin,
    input  logic [CW-1:0]     ld_cleanwin,
    input  logic [5:0]        ld_wstate,
    output logic [CW-1:0]     cansave,
    output logic [CW-1:0]     canrestore,
    output logic [CW-1:0]     otherwin,
    output logic [CW-1:0]     cleanwin,
    output logic [CW-1:0]     cwp,
    output logic              trap_valid,
    output logic [7:0]        trap_type
);
    localparam logic [CW-1:0] TOPV = CW'(NWIN - 1);
    localparam logic [CW-1:0] INIT_CS = CW'(NWIN - 2);

    win_op_e          op_e;
    logic [CW-1:0]    cs_q, cr_q, ow_q, cl_q;
    logic [CW-1:0]    cs_n, cr_n, ow_n, cl_n;
    logic [WS_W-1:0]  ws_q;
    trap_kind_e       kind;
    ptr_step_e        step;
    logic [TT_W-1:0]  code;

    assign op_e = win_op_e'(op);

    win_op_decide #(.NWIN(NWIN), .CW(CW)) u_decide (
        .op    (op_e),
        .cs    (cs_q),
        .cr    (cr_q),
        .ow    (ow_q),
        .cl    (cl_q),
        .ld_cs (ld_cansave),
        .ld_cr (ld_canrestore),
        .ld_ow (ld_otherwin),
        .ld_cl (ld_cleanwin),
        .cs_n  (cs_n),
        .cr_n  (cr_n),
        .ow_n  (ow_n),
        .cl_n  (cl_n),
        .kind  (kind),
        .step  (step)
    );

    win_trap_enc u_enc (
        .kind     (kind),
        .other_nz (ow_q != '0),
        .ws       (ws_q),
        .code     (code)
    );

    win_cwp_reg #(.NWIN(NWIN), .CW(CW), .WV(WV)) u_cwp (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .wr_val (set_val),
        .arch   (cwp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q       <= INIT_CS;
            cr_q       <= '0;
            ow_q       <= '0;
            cl_q       <= TOPV;
            ws_q       <= '0;
            trap_valid <= 1'b0;
            trap_type  <= '0;
        end else begin
            cs_q       <= cs_n;
            cr_q       <= cr_n;
            ow_q       <= ow_n;
            cl_q       <= cl_n;
            if (op_e == WOP_LOAD) ws_q <= ld_wstate;
            trap_valid <= (kind != TK_NONE);
            trap_type  <= (kind != TK_NONE) ? code : '0;
        end
    end

    assign cansave    = cs_q;
    assign canrestore = cr_q;
    assign otherwin   = ow_q;
    assign cleanwin   = cl_q;

    AST_TRAP_FREEZES: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (cs_q == $past(cs_q) && cr_q == $past(cr_q) &&
                        ow_q == $past(ow_q) && cl_q == $past(cl_q) &&
                        cwp == $past(cwp))); // R12

    AST_TRAP_CODE_FORM: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (trap_type[7] || trap_type == TT_CLEANWIN)); // R3

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op_e == WOP_FLUSH) |->
            (cs_q == $past(cs_q) && cr_q == $past(cr_q) &&
             ow_q == $past(ow_q) && cl_q == $past(cl_q))); // R8

    AST_CLEAN_CAP: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && op_e == WOP_RESTORED) && $past(cl_q) == TOPV)
            |-> cl_q == TOPV); // R10

    AST_SAVE_CONSERVES: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && op_e == WOP_SAVE) && !trap_valid)
            |-> (cs_q + cr_q) == ($past(cs_q) + $past(cr_q))); // R5

    AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op_e == WOP_IDLE) |-> !trap_valid); // R13
endmodule

// File: tb/tb_win_state_unit.sv
module tb_win_state_unit;
    localparam int CLK_P = 10;
    localparam int NWIN  = 8;
    localparam int CW    = 3;
    localparam int WV    = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    op;
    logic [WV-1:0] set_val;
    logic [CW-1:0] ld_cs, ld_cr, ld_ow, ld_cl;
    logic [5:0]    ld_ws;
    logic [CW-1:0] cansave, canrestore, otherwin, cleanwin, cwp;
    logic          trap_valid;
    logic [7:0]    trap_type;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    win_state_unit #(.NWIN(NWIN), .CW(CW), .WV(WV)) dut (
        .clk(clk), .rst(rst), .op(op), .set_val(set_val),
        .ld_cansave(ld_cs), .ld_canrestore(ld_cr), .ld_otherwin(ld_ow),
        .ld_cleanwin(ld_cl), .ld_wstate(ld_ws),
        .cansave(cansave), .canrestore(canrestore), .otherwin(otherwin),
        .cleanwin(cleanwin), .cwp(cwp), .trap_valid(trap_valid),
        .trap_type(trap_type)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: act=%0d exp=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int tcode(input int base, input int ow, input int ws);
        if (ow != 0) return base | 32'h20 | (((ws >> 3) & 7) << 2);
        return base | ((ws & 7) << 2);
    endfunction

    task automatic step_op(input int o);
        op = 3'(o);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; op = 3'd0; set_val = '0;
        ld_cs = '0; ld_cr = '0; ld_ow = '0; ld_cl = '0; ld_ws = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cansave", cansave, NWIN - 2);
        chk("R1 canrestore", canrestore, 0);
        chk("R1 otherwin", otherwin, 0);
        chk("R1 cleanwin", cleanwin, NWIN - 1);
        chk("R1 cwp", cwp, NWIN - 1);
        chk("R1 trap_valid", trap_valid, 0);
        chk("R1 trap_type", trap_type, 0);

        for (int cs = 0; cs < NWIN; cs++)
        for (int cr = 0; cr < NWIN; cr++)
        for (int ow = 0; ow < 4; ow++)
        for (int cl = 0; cl < NWIN; cl++)
        for (int o = 1; o <= 5; o++) begin
            int ws, wv, acwp;
            int e_cs, e_cr, e_ow, e_cl, e_cwp, e_tv, e_tt;
            string tag;
            ws = (cs * 5 + cl * 3 + ow * 7 + cr) & 63;
            wv = (cs * 37 + cl * 11 + ow * 3 + cr * 53 + o) & 255;
            ld_cs = CW'(cs); ld_cr = CW'(cr); ld_ow = CW'(ow);
            ld_cl = CW'(cl); ld_ws = 6'(ws);
            step_op(7);
            set_val = 8'(wv);
            step_op(6);
            acwp = wv % NWIN;
            if (o == 1 && cs == 0 && cr == 0 && ow == 0 && cl == 0)
                chk("R11 load/cwp write", cwp, acwp);
            e_cs = cs; e_cr = cr; e_ow = ow; e_cl = cl; e_cwp = acwp;
            e_tv = 0; e_tt = 0;
            case (o)
                1: begin
                    tag = (ow != 0) ? "R3 save" : "R2 save";
                    if (cs == 0) begin e_tv = 1; e_tt = tcode(8'h80, ow, ws); end
                    else if (cl == cr) begin tag = "R4 save"; e_tv = 1; e_tt = 8'h24; end
                    else begin
                        tag = "R5 save";
                        e_cs = (cs - 1) & 7; e_cr = (cr + 1) & 7;
                        e_cwp = (acwp + 1) % NWIN;
                    end
                end
                2: begin
                    tag = (ow != 0) ? "R3 restore" : "R6 restore";
                    if (cr == 0) begin e_tv = 1; e_tt = tcode(8'hC0, ow, ws); end
                    else begin
                        tag = "R7 restore";
                        e_cs = (cs + 1) & 7; e_cr = (cr - 1) & 7;
                        e_cwp = (acwp + NWIN - 1) % NWIN;
                    end
                end
                3: begin
                    tag = "R8 flush";
                    if (cs != NWIN - 2) begin e_tv = 1; e_tt = tcode(8'h80, ow, ws); end
                end
                4: begin
                    tag = "R9 saved";
                    e_cs = (cs + 1) & 7;
                    if (ow == 0) e_cr = (cr - 1) & 7; else e_ow = ow - 1;
                end
                default: begin
                    tag = "R10 restored";
                    e_cr = (cr + 1) & 7;
                    if (cl < NWIN - 1) e_cl = cl + 1;
                    if (ow == 0) e_cs = (cs - 1) & 7; else e_ow = ow - 1;
                end
            endcase
            if (e_tv != 0) tag = {tag, " R12"};
            step_op(o);
            op = 3'd0;
            chk({tag, " cansave"}, cansave, e_cs);
            chk({tag, " canrestore"}, canrestore, e_cr);
            chk({tag, " otherwin"}, otherwin, e_ow);
            chk({tag, " cleanwin"}, cleanwin, e_cl);
            chk({tag, " cwp"}, cwp, e_cwp);
            chk({tag, " trap_valid"}, trap_valid, e_tv);
            chk({tag, " trap_type"}, trap_type, e_tt);
        end

        // R13 trap pulse lasts one cycle
        ld_cs = '0; ld_cr = 3'd2; ld_ow = '0; ld_cl = 3'd4; ld_ws = 6'h05;
        step_op(7);
        step_op(1);
        chk("R13 trap due", trap_valid, 1);
        chk("R13 trap code", trap_type, 8'h80 | (5 << 2));
        step_op(0);
        chk("R13 trap gone", trap_valid, 0);
        chk("R13 type cleared", trap_type, 0);

        // R11 pointer write above range is reduced
        set_val = 8'd203;
        step_op(6);
        op = 3'd0;
        chk("R11 modulo write", cwp, 203 % NWIN);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule